// File: doc/BRIEF.md
# Advanced Error Status Logger

This block keeps the error bookkeeping of a serial-link endpoint's advanced error capability. Two groups of single-cycle event inputs arrive from the link and transaction layers, one bit per error source. Twelve of them are uncorrectable and six are correctable. The block records each event in a sticky status register, which software clears by writing ones to it. Per-bit masks decide whether an error is recorded and whether it is reported. For uncorrectable errors, a per-bit severity selects between the fatal and the non-fatal message class.

Reporting to the root complex is done with three one-cycle request pulses: correctable, non-fatal and fatal. A first-error pointer holds the index of the earliest recorded uncorrectable error. It stays frozen until software clears the status bit it names. The block also keeps a four-bit device status summary and a small control register for the end-to-end CRC generate and check enables.

Software reaches every register through a plain address/write port. Read data comes back registered.

Top module: `aer_err_logger`

## Requirements
- R1: Uncorrectable status (address 0, bits 11:0) sets bit i in the cycle after `unc_evt[i]` pulses with mask bit i clear. A set bit stays set until a write of 1 to it at address 0. Written zeros change nothing. The source index order is: 0 link protocol, 1 surprise down, 2 poisoned packet, 3 flow control protocol, 4 completion timeout, 5 completer abort, 6 unexpected completion, 7 receiver overflow, 8 malformed packet, 9 end-to-end CRC, 10 unsupported request, 11 access control violation.
- R2: Uncorrectable mask (address 1, read/write, reset 0). When bit i is 1, an event on source i sets no status bit and raises no message pulse.
- R3: Uncorrectable severity (address 2, read/write, reset 0). One cycle after an unmasked event, `msg_fatal` pulses if the event's severity bit is 1, and `msg_nonfatal` pulses if it is 0. Both pulse when the same cycle holds both kinds.
- R4: Correctable status (address 3, bits 5:0, write-1-to-clear) records every correctable event, masked or not. Correctable mask (address 4) suppresses only the `msg_cor` pulse, which comes one cycle after an unmasked event. The index order is: 0 receiver, 1 bad packet, 2 bad link packet, 3 replay number rollover, 4 replay timer timeout, 5 advisory non-fatal.
- R5: After the synchronous reset, all status, mask, severity, enable and pointer fields are 0, except correctable mask bit 5, which is 1. `reg_rdata` and all message outputs are 0.
- R6: Capture-and-hold of the first-error pointer. While the status bit it points to is clear, the pointer loads the lowest index among the recorded uncorrectable events of that cycle. While that status bit is set, the pointer holds its value.
- R7: When an event and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R8: Control register (address 5). Bits 3:0 are the read-only first-error pointer. Bit 8 (CRC generation capable) and bit 10 (CRC check capable) are read-only and read 1. Bit 9 (generation enable) and bit 11 (check enable) are read/write, reset 0.
- R9: Device status (address 6, write-1-to-clear). Bit 0 sets on any correctable event. Bit 1 sets on any uncorrectable event with severity 0. Bit 2 sets on any uncorrectable event with severity 1. Bit 3 sets on an event at source 10. All four bits set regardless of the masks.
- R10: `reg_rdata` shows, one cycle later, the register selected by `reg_addr`, using the contents before that cycle's update. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| unc_evt | input | 12 | uncorrectable error event pulses |
| cor_evt | input | 6 | correctable error event pulses |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 3 | register address |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | registered read data |
| msg_cor | output | 1 | correctable message request pulse |
| msg_nonfatal | output | 1 | non-fatal message request pulse |
| msg_fatal | output | 1 | fatal message request pulse |

## Verification
The bench targets the cycle in which a new event and a clearing write meet on the same status bit. A design that gives the write priority loses that error silently. It fires several uncorrectable events in one cycle and then more events while the pointer is locked. A pointer that takes the highest index, or reloads while locked, reads back a wrong value. It also checks that masked correctable events still reach status while masked uncorrectable ones do not. A design that applies the masks the same way to both groups shows a status mismatch or a stray message pulse. Severity changes between events, so a fatal/non-fatal swap shows up on the message outputs and in device status.

// File: rtl/aer_pkg.sv
package aer_pkg;
  localparam int A_UST  = 0;
  localparam int A_UMSK = 1;
  localparam int A_USEV = 2;
  localparam int A_CST  = 3;
  localparam int A_CMSK = 4;
  localparam int A_CTL  = 5;
  localparam int A_DSTA = 6;

  localparam int CTL_GEN_CAP = 8;
  localparam int CTL_GEN_EN  = 9;
  localparam int CTL_CHK_CAP = 10;
  localparam int CTL_CHK_EN  = 11;

  localparam int DS_COR = 0;
  localparam int DS_NF  = 1;
  localparam int DS_FAT = 2;
  localparam int DS_UR  = 3;
  localparam int DS_W   = 4;
endpackage

// File: rtl/aer_unc_bank.sv
module aer_unc_bank #(
  parameter int NU = 12,
  parameter int FEP_W = 4,
  parameter logic [NU-1:0] SEV_RST = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NU-1:0]    evt,
  input  logic             wr_st,
  input  logic             wr_mask,
  input  logic             wr_sev,
  input  logic [NU-1:0]    wdata,
  output logic [NU-1:0]    st,
  output logic [NU-1:0]    mask,
  output logic [NU-1:0]    sev,
  output logic [FEP_W-1:0] fep,
  output logic             fatal_p,
  output logic             nonfatal_p
);
  logic [NU-1:0]    rec;
  logic [NU-1:0]    clr;
  logic [FEP_W-1:0] low_idx;
  logic             fep_free;

  assign rec      = evt & ~mask;
  assign clr      = wr_st ? wdata : '0;
  assign fep_free = ~st[fep];

  always_comb begin
    low_idx = '0;
    for (int i = NU - 1; i >= 0; i--) begin
      if (rec[i]) low_idx = FEP_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= '0;
      mask       <= '0;
      sev        <= SEV_RST;
      fep        <= '0;
      fatal_p    <= 1'b0;
      nonfatal_p <= 1'b0;
    end else begin
      st         <= (st & ~clr) | rec;
      if (wr_mask) mask <= wdata;
      if (wr_sev)  sev  <= wdata;
      if (fep_free && (|rec)) fep <= low_idx;
      fatal_p    <= |(rec & sev);
      nonfatal_p <= |(rec & ~sev);
    end
  end
endmodule

// File: rtl/aer_cor_bank.sv
module aer_cor_bank #(
  parameter int NC = 6,
  parameter logic [NC-1:0] MASK_RST = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NC-1:0] evt,
  input  logic          wr_st,
  input  logic          wr_mask,
  input  logic [NC-1:0] wdata,
  output logic [NC-1:0] st,
  output logic [NC-1:0] mask,
  output logic          cor_p
);
  logic [NC-1:0] clr;
  assign clr = wr_st ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= '0;
      mask  <= MASK_RST;
      cor_p <= 1'b0;
    end else begin
      st    <= (st & ~clr) | evt;
      if (wr_mask) mask <= wdata;
      cor_p <= |(evt & ~mask);
    end
  end
endmodule

// File: rtl/aer_devsta.sv
module aer_devsta #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] det,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] sta
);
  always_ff @(posedge clk) begin
    if (rst) sta <= '0;
    else     sta <= (sta & ~(wr ? wdata : '0)) | det;
  end
endmodule

// File: rtl/aer_err_logger.sv
module aer_err_logger
  import aer_pkg::*;
#(
  parameter int NU      = 12,
  parameter int NC      = 6,
  parameter int AW      = 3,
  parameter int DW      = 32,
  parameter int UR_IDX  = 10,
  parameter int ANF_IDX = 5,
  parameter bit GEN_CAP = 1'b1,
  parameter bit CHK_CAP = 1'b1,
  parameter logic [NU-1:0] SEV_RST = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NU-1:0] unc_evt,
  input  logic [NC-1:0] cor_evt,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          msg_cor,
  output logic          msg_nonfatal,
  output logic          msg_fatal
);
  localparam int FEP_W = $clog2(NU);
  localparam logic [NC-1:0] CMSK_RST = NC'(1) << ANF_IDX;

  logic [NU-1:0]    unc_st, unc_mask, unc_sev;
  logic [NC-1:0]    cor_st, cor_mask;
  logic [FEP_W-1:0] fep;
  logic [DS_W-1:0]  dsta, ds_det;
  logic             gen_en, chk_en;
  logic             wr_ust, wr_umsk, wr_usev, wr_cst, wr_cmsk, wr_ctl, wr_dsta;
  logic [DW-1:0]    rd_next;

  assign wr_ust  = reg_we && (reg_addr == AW'(A_UST));
  assign wr_umsk = reg_we && (reg_addr == AW'(A_UMSK));
  assign wr_usev = reg_we && (reg_addr == AW'(A_USEV));
  assign wr_cst  = reg_we && (reg_addr == AW'(A_CST));
  assign wr_cmsk = reg_we && (reg_addr == AW'(A_CMSK));
  assign wr_ctl  = reg_we && (reg_addr == AW'(A_CTL));
  assign wr_dsta = reg_we && (reg_addr == AW'(A_DSTA));

  aer_unc_bank #(.NU(NU), .FEP_W(FEP_W), .SEV_RST(SEV_RST)) u_unc (
    .clk(clk), .rst(rst), .evt(unc_evt),
    .wr_st(wr_ust), .wr_mask(wr_umsk), .wr_sev(wr_usev),
    .wdata(reg_wdata[NU-1:0]),
    .st(unc_st), .mask(unc_mask), .sev(unc_sev), .fep(fep),
    .fatal_p(msg_fatal), .nonfatal_p(msg_nonfatal)
  );

  aer_cor_bank #(.NC(NC), .MASK_RST(CMSK_RST)) u_cor (
    .clk(clk), .rst(rst), .evt(cor_evt),
    .wr_st(wr_cst), .wr_mask(wr_cmsk), .wdata(reg_wdata[NC-1:0]),
    .st(cor_st), .mask(cor_mask), .cor_p(msg_cor)
  );

  // detection summary ignores the masks
  always_comb begin
    ds_det         = '0;
    ds_det[DS_COR] = |cor_evt;
    ds_det[DS_NF]  = |(unc_evt & ~unc_sev);
    ds_det[DS_FAT] = |(unc_evt & unc_sev);
    ds_det[DS_UR]  = unc_evt[UR_IDX];
  end

  aer_devsta #(.W(DS_W)) u_ds (
    .clk(clk), .rst(rst), .det(ds_det), .wr(wr_dsta),
    .wdata(reg_wdata[DS_W-1:0]), .sta(dsta)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_en <= 1'b0;
      chk_en <= 1'b0;
    end else if (wr_ctl) begin
      gen_en <= reg_wdata[CTL_GEN_EN];
      chk_en <= reg_wdata[CTL_CHK_EN];
    end
  end

  always_comb begin
    rd_next = '0;
    case (int'(reg_addr))
      A_UST:  rd_next[NU-1:0] = unc_st;
      A_UMSK: rd_next[NU-1:0] = unc_mask;
      A_USEV: rd_next[NU-1:0] = unc_sev;
      A_CST:  rd_next[NC-1:0] = cor_st;
      A_CMSK: rd_next[NC-1:0] = cor_mask;
      A_CTL: begin
        rd_next[FEP_W-1:0]  = fep;
        rd_next[CTL_GEN_CAP] = GEN_CAP;
        rd_next[CTL_GEN_EN]  = gen_en;
        rd_next[CTL_CHK_CAP] = CHK_CAP;
        rd_next[CTL_CHK_EN]  = chk_en;
      end
      A_DSTA: rd_next[DS_W-1:0] = dsta;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end
endmodule

// File: rtl/aer_err_logger_chk.sv
module aer_err_logger_chk #(
  parameter int NU = 12,
  parameter int NC = 6,
  parameter int AW = 3,
  parameter int DW = 32,
  parameter int FEP_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NU-1:0]    unc_evt,
  input logic [NC-1:0]    cor_evt,
  input logic             reg_we,
  input logic [AW-1:0]    reg_addr,
  input logic [DW-1:0]    reg_wdata,
  input logic             msg_cor,
  input logic             msg_fatal,
  input logic [NU-1:0]    unc_st,
  input logic [NU-1:0]    unc_mask,
  input logic [NU-1:0]    unc_sev,
  input logic [NC-1:0]    cor_mask,
  input logic [FEP_W-1:0] fep,
  input logic [3:0]       dsta
);
  // R2
  masked_no_record_chk: assert property (@(posedge clk) disable iff (rst)
    ((unc_st & ~$past(unc_st) & ~$past(unc_evt & ~unc_mask)) == '0));

  // R3
  fatal_needs_cause_chk: assert property (@(posedge clk) disable iff (rst)
    msg_fatal |-> $past(|(unc_evt & ~unc_mask & unc_sev)));

  // R4
  cor_msg_cause_chk: assert property (@(posedge clk) disable iff (rst)
    msg_cor |-> $past(|(cor_evt & ~cor_mask)));

  // R6
  fep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    unc_st[fep] |=> $stable(fep));

  // R1
  w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == AW'(0)) |=>
      ((unc_st & $past(reg_wdata[NU-1:0] & ~(unc_evt & ~unc_mask))) == '0));

  // R9
  fatal_summary_chk: assert property (@(posedge clk) disable iff (rst)
    msg_fatal |-> dsta[2]);
endmodule

bind aer_err_logger aer_err_logger_chk #(
  .NU(NU), .NC(NC), .AW(AW), .DW(DW), .FEP_W(FEP_W)
) u_chk (
  .clk(clk), .rst(rst), .unc_evt(unc_evt), .cor_evt(cor_evt),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .msg_cor(msg_cor), .msg_fatal(msg_fatal),
  .unc_st(unc_st), .unc_mask(unc_mask), .unc_sev(unc_sev),
  .cor_mask(cor_mask), .fep(fep), .dsta(dsta)
);

// File: tb/tb_aer_err_logger.sv
module tb_aer_err_logger;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] unc_evt = '0;
  logic [5:0]  cor_evt = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msg_cor, msg_nonfatal, msg_fatal;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string tag = "R5";

  always #2 clk = ~clk;

  aer_err_logger dut (
    .clk(clk), .rst(rst), .unc_evt(unc_evt), .cor_evt(cor_evt),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .msg_cor(msg_cor),
    .msg_nonfatal(msg_nonfatal), .msg_fatal(msg_fatal)
  );

  // behavioural reference state
  logic [11:0] m_ust, m_umsk, m_usev;
  logic [5:0]  m_cst, m_cmsk;
  logic [3:0]  m_fep, m_ds;
  logic        m_gen, m_chk;

  function automatic logic [31:0] model_read(input int a);
    logic [31:0] v = '0;
    case (a)
      0: v[11:0] = m_ust;
      1: v[11:0] = m_umsk;
      2: v[11:0] = m_usev;
      3: v[5:0]  = m_cst;
      4: v[5:0]  = m_cmsk;
      5: begin v[3:0] = m_fep; v[8] = 1; v[9] = m_gen; v[10] = 1; v[11] = m_chk; end
      6: v[3:0]  = m_ds;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic string addr_tag(input int a);
    case (a)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3, 4: return "R4";
      5: return "R8 R6";
      6: return "R9";
      default: return "R10";
    endcase
  endfunction

  always begin
    logic [31:0] e_rd;
    logic        e_cor, e_nf, e_fat;
    logic [11:0] rec;
    int          a;
    @(posedge clk);
    a = int'(reg_addr);
    if (rst) begin
      m_ust = '0; m_umsk = '0; m_usev = '0; m_cst = '0; m_cmsk = 6'b100000;
      m_fep = '0; m_ds = '0; m_gen = 0; m_chk = 0;
      e_rd = '0; e_cor = 0; e_nf = 0; e_fat = 0;
    end else begin
      e_rd  = model_read(a);
      rec   = unc_evt & ~m_umsk;
      e_fat = |(rec & m_usev);
      e_nf  = |(rec & ~m_usev);
      e_cor = |(cor_evt & ~m_cmsk);
      if (!m_ust[m_fep] && rec != 0) begin
        for (int i = 11; i >= 0; i--) if (rec[i]) m_fep = 4'(i);
      end
      if (reg_we) begin
        case (a)
          0: m_ust = m_ust & ~reg_wdata[11:0];
          1: m_umsk = reg_wdata[11:0];
          2: m_usev = reg_wdata[11:0];
          3: m_cst = m_cst & ~reg_wdata[5:0];
          4: m_cmsk = reg_wdata[5:0];
          5: begin m_gen = reg_wdata[9]; m_chk = reg_wdata[11]; end
          6: m_ds = m_ds & ~reg_wdata[3:0];
          default: ;
        endcase
      end
      m_ust = m_ust | rec;
      m_cst = m_cst | cor_evt;
      if (|cor_evt) m_ds[0] = 1;
      if (|(unc_evt & ~m_usev)) m_ds[1] = 1;
      if (|(unc_evt & m_usev)) m_ds[2] = 1;
      if (unc_evt[10]) m_ds[3] = 1;
    end
    #1;
    checks++;
    if (reg_rdata !== e_rd || msg_cor !== e_cor || msg_nonfatal !== e_nf || msg_fatal !== e_fat) begin
      errors++;
      $display("FAIL [%s] %s addr=%0d rdata=%h exp=%h cor/nf/fat=%b%b%b exp=%b%b%b",
               tag, addr_tag(a), a, reg_rdata, e_rd, msg_cor, msg_nonfatal, msg_fatal,
               e_cor, e_nf, e_fat);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    unc_evt = '0; cor_evt = '0; reg_we = 0;
  endtask

  task automatic step(input logic [11:0] u, input logic [5:0] c, input bit we,
                      input int a, input logic [31:0] d);
    @(negedge clk);
    unc_evt = u; cor_evt = c; reg_we = we; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    unc_evt = '0; cor_evt = '0; reg_we = 0;
  endtask

  task automatic look(input int a);
    @(negedge clk);
    reg_addr = 3'(a);
    idle(2);
  endtask

  initial begin
    logic [15:0] lf = 16'hACE1;
    repeat (3) @(negedge clk);
    rst = 0;
    tag = "R5";
    for (int a = 0; a < 8; a++) look(a);

    tag = "R1";
    step(12'h008, '0, 0, 0, 0); look(0);
    step('0, '0, 1, 0, 32'h0);  look(0);
    step('0, '0, 1, 0, 32'h8);  look(0);

    tag = "R2";
    step('0, '0, 1, 1, 32'h010); step(12'h010, '0, 0, 1, 0); idle(2); look(0);

    tag = "R3";
    step('0, '0, 1, 2, 32'h004);
    step(12'h004, '0, 0, 2, 0); idle(1);
    step(12'h002, '0, 0, 2, 0); idle(1);
    step(12'h006, '0, 0, 2, 0); idle(1);
    step('0, '0, 1, 0, 32'hFFF);

    tag = "R4";
    step('0, 6'h21, 0, 3, 0); idle(1); look(3); look(4);
    step('0, '0, 1, 3, 32'h3F); look(3);

    tag = "R6";
    step(12'h280, '0, 0, 5, 0); look(5);
    step(12'h002, '0, 0, 5, 0); look(5);
    step('0, '0, 1, 0, 32'h080); look(5);
    step(12'h800, '0, 0, 5, 0); look(5); look(0);
    step('0, '0, 1, 0, 32'hFFF);

    tag = "R7";
    step(12'h100, '0, 0, 0, 0);
    step(12'h100, '0, 1, 0, 32'h100); look(0);
    step('0, '0, 1, 0, 32'hFFF);

    tag = "R8";
    step('0, '0, 1, 5, 32'hFFFF_FFFF); look(5);
    step('0, '0, 1, 5, 32'h0); look(5);

    tag = "R9";
    step(12'h400, 6'h01, 0, 6, 0); look(6);
    step('0, '0, 1, 6, 32'h5); look(6);
    step('0, '0, 1, 6, 32'hF); look(6);

    tag = "R10";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      unc_evt   = (lf[3:0] == 0) ? 12'(lf >> 4) & 12'(1 << lf[7:4]) : '0;
      cor_evt   = (lf[2:0] == 1) ? 6'(lf >> 9) : '0;
      reg_we    = (lf[4:2] == 3);
      reg_addr  = 3'(lf[15:13]);
      reg_wdata = {16'h0, lf ^ 16'h5A3C};
    end
    idle(3);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule